// File: doc/BRIEF.md
# FS/GS Segment Builder for Enclave Entry

This block prepares the two thread-local segments (FS and GS) that a processor installs when it resumes execution inside an enclave. For each segment it forms a proposed base and limit, decides whether the result is legal for the current operating mode, and, when both segments are legal, produces the new hidden descriptor fields. In the same cycle it keeps a copy of the FS and GS descriptors that were in force before the swap, so that a later exit can put them back.

In 32-bit mode the base is the per-thread offset added to the enclave base. The end of the segment is that base plus the per-segment limit field. The segment must fit inside the data segment. A segment that wraps past the top of the 32-bit space is only accepted when the data segment covers all 4 GiB. In 64-bit mode the bases come from values saved in the thread's register area, and only canonical form is required. In both modes the offsets must be page aligned. A request is a one-cycle pulse on `req_i`. Exactly one cycle later `done_o` pulses with `fault_o`. If a fault is reported, no descriptor output changes.

Top module: `seg_entry_builder`

## Requirements
- R1: Each cycle with `req_i` high is followed in the next cycle by exactly one cycle of `done_o` high. `done_o` is low in every cycle not preceded by a request. After a synchronous reset all outputs are zero.
- R2: If the low 12 bits of either offset (`fs_ofs_i`, `gs_ofs_i`) are not all zero, the request faults. This holds in both modes.
- R3: In 32-bit mode the new base is (offset + `encl_base_i`) modulo 2^32, zero-extended to 64 bits. In both modes the new limit output equals the segment's limit field input.
- R4: In 32-bit mode, let the segment end be (base + limit field) modulo 2^32. When the end is not below the base, an end greater than `ds_limit_i` is a fault. An end equal to `ds_limit_i` is accepted.
- R5: In 32-bit mode, when the end is below the base (wrap), the request faults unless `ds_limit_i` is all ones.
- R6: In 64-bit mode the new base is the register-area value (`fs_rbase_i` / `gs_rbase_i`). It faults if bits 63 down to 47 are not all equal. `ds_limit_i` has no effect in this mode.
- R7: The new access-rights word uses this layout: [3:0] type, [4] W, [5] S, [7:6] DPL, [8] P, [9] AVL, [10] L, [11] B, [12] G, [13] unusable. On success, type is 0001b; S, P, B and G are 1; unusable is 0.
- R8: On success, the new W, DPL, AVL and L fields are copied from `ds_w_i`, `ds_dpl_i`, `ds_avl_i` and `ds_l_i`. Both new selectors are 16'h000B.
- R9: On success, the saved outputs take the selector, base, limit and access rights presented on the current FS/GS inputs with the request.
- R10: On a fault, every new-descriptor output and every saved output keeps its previous value.
- R11: FS and GS are checked independently. A fault on either segment alone faults the request and blocks the update of both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | One-cycle request to build the segments |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| encl_base_i | input | 32 | Enclave base address (32-bit mode) |
| ds_limit_i | input | 32 | Byte-granular data-segment limit |
| ds_w_i | input | 1 | Data-segment writable bit |
| ds_dpl_i | input | 2 | Data-segment privilege level |
| ds_avl_i | input | 1 | Data-segment available bit |
| ds_l_i | input | 1 | Data-segment long bit |
| fs_ofs_i | input | 32 | FS offset from enclave base |
| fs_lim_i | input | 32 | FS limit field |
| fs_rbase_i | input | 64 | FS base from register area (64-bit mode) |
| gs_ofs_i | input | 32 | GS offset from enclave base |
| gs_lim_i | input | 32 | GS limit field |
| gs_rbase_i | input | 64 | GS base from register area (64-bit mode) |
| fs_cur_sel_i | input | 16 | Current FS selector |
| fs_cur_base_i | input | 64 | Current FS base |
| fs_cur_lim_i | input | 32 | Current FS limit |
| fs_cur_ar_i | input | 14 | Current FS access rights |
| gs_cur_sel_i | input | 16 | Current GS selector |
| gs_cur_base_i | input | 64 | Current GS base |
| gs_cur_lim_i | input | 32 | Current GS limit |
| gs_cur_ar_i | input | 14 | Current GS access rights |
| done_o | output | 1 | Result valid, one cycle after request |
| fault_o | output | 1 | General-protection fault for this request |
| fs_sel_o | output | 16 | New FS selector |
| fs_base_o | output | 64 | New FS base |
| fs_lim_o | output | 32 | New FS limit |
| fs_ar_o | output | 14 | New FS access rights |
| gs_sel_o | output | 16 | New GS selector |
| gs_base_o | output | 64 | New GS base |
| gs_lim_o | output | 32 | New GS limit |
| gs_ar_o | output | 14 | New GS access rights |
| fs_sav_sel_o | output | 16 | Saved FS selector |
| fs_sav_base_o | output | 64 | Saved FS base |
| fs_sav_lim_o | output | 32 | Saved FS limit |
| fs_sav_ar_o | output | 14 | Saved FS access rights |
| gs_sav_sel_o | output | 16 | Saved GS selector |
| gs_sav_base_o | output | 64 | Saved GS base |
| gs_sav_lim_o | output | 32 | Saved GS limit |
| gs_sav_ar_o | output | 14 | Saved GS access rights |

## Verification
The assertions assume that every request input, including the current descriptors and the register-area bases, is stable through the clock edge that samples `req_i`. They also assume that `mode64_i` means the same thing for the whole of that edge. The properties compare each result with the inputs one cycle earlier. The stimulus therefore changes inputs only on falling edges and raises `req_i` for single cycles, sometimes back to back. It covers both modes, aligned and misaligned offsets, segments that end exactly at, or one byte past, the data-segment limit, wrapped segments with and without a full 4 GiB data segment, and canonical and non-canonical bases on either side of bit 47.

// File: rtl/segb_pkg.sv
// Package: shared widths, access-rights field positions and helper
// functions for the FS/GS segment builder.
// Assumes 64-bit architectural bases and a 14-bit access-rights word.
package segb_pkg;
    localparam int unsigned BASE_W  = 64;
    localparam int unsigned SEL_W   = 16;
    localparam int unsigned AR_W    = 14;
    localparam int unsigned LIM_W   = 32;
    localparam int unsigned NSEG    = 2;

    // access-rights field positions
    localparam int unsigned AR_TYPE_LO = 0;
    localparam int unsigned AR_W_BIT   = 4;
    localparam int unsigned AR_S_BIT   = 5;
    localparam int unsigned AR_DPL_LO  = 6;
    localparam int unsigned AR_P_BIT   = 8;
    localparam int unsigned AR_AVL_BIT = 9;
    localparam int unsigned AR_L_BIT   = 10;
    localparam int unsigned AR_B_BIT   = 11;
    localparam int unsigned AR_G_BIT   = 12;
    localparam int unsigned AR_U_BIT   = 13;

    localparam logic [3:0]       NEW_TYPE = 4'b0001;
    localparam logic [SEL_W-1:0] NEW_SEL  = 16'h000B;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  lim;
        logic [AR_W-1:0]   ar;
    } seg_desc_t;

    // True when bits 63..msb of the address are not all the same value.
    function automatic logic canon_bad(input logic [BASE_W-1:0] a,
                                       input int unsigned msb);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < BASE_W; i++) begin
            if (i >= int'(msb) && a[i] != a[BASE_W-1]) bad = 1'b1;
        end
        return bad;
    endfunction
endpackage

// File: rtl/segb_span_chk.sv
// Module: per-segment legality check and base computation.
// Assumes the offset, the limit field and the enclave base share the width SEG_W.
// In 32-bit mode the arithmetic wraps modulo 2^SEG_W.
module segb_span_chk
    import segb_pkg::*;
#(
    parameter int unsigned SEG_W     = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned CANON_MSB = 47
) (
    input  logic              mode64,
    input  logic [SEG_W-1:0]  ofs,
    input  logic [SEG_W-1:0]  lim,
    input  logic [SEG_W-1:0]  encl_base,
    input  logic [SEG_W-1:0]  ds_limit,
    input  logic [BASE_W-1:0] rbase,
    output logic [BASE_W-1:0] base_o,
    output logic              fault_o
);
    localparam int unsigned PAD_W = BASE_W - SEG_W;

    logic [SEG_W-1:0] base_n;
    logic [SEG_W-1:0] end_n;
    logic             wrapped;
    logic             ds_full;
    logic             span_bad;
    logic             align_bad;
    logic             nc_bad;

    // 32-bit base/end arithmetic and containment decision
    always_comb begin
        base_n   = ofs + encl_base;
        end_n    = base_n + lim;
        wrapped  = end_n < base_n;
        ds_full  = &ds_limit;
        span_bad = wrapped ? !ds_full : (end_n > ds_limit);
    end

    // alignment and canonical-form checks
    always_comb begin
        align_bad = |ofs[PAGE_BITS-1:0];
        nc_bad    = canon_bad(rbase, CANON_MSB);
    end

    // mode selection of base and fault
    always_comb begin
        base_o  = mode64 ? rbase : {{PAD_W{1'b0}}, base_n};
        fault_o = align_bad | (mode64 ? nc_bad : span_bad);
    end
endmodule

// File: rtl/segb_ar_build.sv
// Module: forms the access-rights word for a freshly built FS/GS segment.
// Fixed fields come from the package; W, DPL, AVL and L are taken from the data segment.
module segb_ar_build
    import segb_pkg::*;
(
    input  logic            ds_w,
    input  logic [1:0]      ds_dpl,
    input  logic            ds_avl,
    input  logic            ds_l,
    output logic [AR_W-1:0] ar_o
);
    // pack the fixed and copied fields into the access-rights word
    always_comb begin
        ar_o = '0;
        ar_o[AR_TYPE_LO +: 4]  = NEW_TYPE;
        ar_o[AR_W_BIT]         = ds_w;
        ar_o[AR_S_BIT]         = 1'b1;
        ar_o[AR_DPL_LO +: 2]   = ds_dpl;
        ar_o[AR_P_BIT]         = 1'b1;
        ar_o[AR_AVL_BIT]       = ds_avl;
        ar_o[AR_L_BIT]         = ds_l;
        ar_o[AR_B_BIT]         = 1'b1;
        ar_o[AR_G_BIT]         = 1'b1;
        ar_o[AR_U_BIT]         = 1'b0;
    end
endmodule

// File: rtl/seg_entry_builder.sv
// Module: top of the FS/GS segment builder.
// It samples a request, checks both segments and, if neither faults, registers
// the new descriptors and the previous ones. The result is available one cycle
// after the request. Assumes inputs are stable at the sampling edge.
module seg_entry_builder
    import segb_pkg::*;
#(
    parameter int unsigned SEG_W     = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned CANON_MSB = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              mode64_i,
    input  logic [SEG_W-1:0]  encl_base_i,
    input  logic [SEG_W-1:0]  ds_limit_i,
    input  logic              ds_w_i,
    input  logic [1:0]        ds_dpl_i,
    input  logic              ds_avl_i,
    input  logic              ds_l_i,
    input  logic [SEG_W-1:0]  fs_ofs_i,
    input  logic [SEG_W-1:0]  fs_lim_i,
    input  logic [BASE_W-1:0] fs_rbase_i,
    input  logic [SEG_W-1:0]  gs_ofs_i,
    input  logic [SEG_W-1:0]  gs_lim_i,
    input  logic [BASE_W-1:0] gs_rbase_i,
    input  logic [SEL_W-1:0]  fs_cur_sel_i,
    input  logic [BASE_W-1:0] fs_cur_base_i,
    input  logic [LIM_W-1:0]  fs_cur_lim_i,
    input  logic [AR_W-1:0]   fs_cur_ar_i,
    input  logic [SEL_W-1:0]  gs_cur_sel_i,
    input  logic [BASE_W-1:0] gs_cur_base_i,
    input  logic [LIM_W-1:0]  gs_cur_lim_i,
    input  logic [AR_W-1:0]   gs_cur_ar_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [SEL_W-1:0]  fs_sel_o,
    output logic [BASE_W-1:0] fs_base_o,
    output logic [LIM_W-1:0]  fs_lim_o,
    output logic [AR_W-1:0]   fs_ar_o,
    output logic [SEL_W-1:0]  gs_sel_o,
    output logic [BASE_W-1:0] gs_base_o,
    output logic [LIM_W-1:0]  gs_lim_o,
    output logic [AR_W-1:0]   gs_ar_o,
    output logic [SEL_W-1:0]  fs_sav_sel_o,
    output logic [BASE_W-1:0] fs_sav_base_o,
    output logic [LIM_W-1:0]  fs_sav_lim_o,
    output logic [AR_W-1:0]   fs_sav_ar_o,
    output logic [SEL_W-1:0]  gs_sav_sel_o,
    output logic [BASE_W-1:0] gs_sav_base_o,
    output logic [LIM_W-1:0]  gs_sav_lim_o,
    output logic [AR_W-1:0]   gs_sav_ar_o
);
    localparam int unsigned LIM_PAD = LIM_W - SEG_W;

    logic [SEG_W-1:0]  ofs_a   [NSEG];
    logic [SEG_W-1:0]  lim_a   [NSEG];
    logic [BASE_W-1:0] rbase_a [NSEG];
    seg_desc_t         cur_a   [NSEG];
    logic [BASE_W-1:0] base_a  [NSEG];
    logic [NSEG-1:0]   seg_flt;
    seg_desc_t         new_q   [NSEG];
    seg_desc_t         sav_q   [NSEG];
    logic [AR_W-1:0]   new_ar;
    logic              any_flt;
    logic              commit;
    logic              done_q;
    logic              fault_q;

    // gather per-segment inputs into arrays (index 0 = FS, 1 = GS)
    always_comb begin
        ofs_a[0]   = fs_ofs_i;
        ofs_a[1]   = gs_ofs_i;
        lim_a[0]   = fs_lim_i;
        lim_a[1]   = gs_lim_i;
        rbase_a[0] = fs_rbase_i;
        rbase_a[1] = gs_rbase_i;
        cur_a[0]   = '{sel: fs_cur_sel_i, base: fs_cur_base_i,
                       lim: fs_cur_lim_i, ar: fs_cur_ar_i};
        cur_a[1]   = '{sel: gs_cur_sel_i, base: gs_cur_base_i,
                       lim: gs_cur_lim_i, ar: gs_cur_ar_i};
    end

    segb_ar_build u_ar (
        .ds_w   (ds_w_i),
        .ds_dpl (ds_dpl_i),
        .ds_avl (ds_avl_i),
        .ds_l   (ds_l_i),
        .ar_o   (new_ar)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        segb_span_chk #(
            .SEG_W     (SEG_W),
            .PAGE_BITS (PAGE_BITS),
            .CANON_MSB (CANON_MSB)
        ) u_chk (
            .mode64    (mode64_i),
            .ofs       (ofs_a[g]),
            .lim       (lim_a[g]),
            .encl_base (encl_base_i),
            .ds_limit  (ds_limit_i),
            .rbase     (rbase_a[g]),
            .base_o    (base_a[g]),
            .fault_o   (seg_flt[g])
        );

        // register new and saved descriptors only on a fault-free request
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                new_q[g] <= '0;
                sav_q[g] <= '0;
            end else if (commit) begin
                new_q[g] <= '{sel: NEW_SEL, base: base_a[g],
                              lim: {{LIM_PAD{1'b0}}, lim_a[g]}, ar: new_ar};
                sav_q[g] <= cur_a[g];
            end
        end
    end

    // a fault in either segment blocks both updates
    always_comb begin
        any_flt = |seg_flt;
        commit  = req_i & ~any_flt;
    end

    // completion pulse and fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= req_i;
            fault_q <= req_i & any_flt;
        end
    end

    // drive the flattened output ports
    always_comb begin
        done_o        = done_q;
        fault_o       = fault_q;
        fs_sel_o      = new_q[0].sel;
        fs_base_o     = new_q[0].base;
        fs_lim_o      = new_q[0].lim;
        fs_ar_o       = new_q[0].ar;
        gs_sel_o      = new_q[1].sel;
        gs_base_o     = new_q[1].base;
        gs_lim_o      = new_q[1].lim;
        gs_ar_o       = new_q[1].ar;
        fs_sav_sel_o  = sav_q[0].sel;
        fs_sav_base_o = sav_q[0].base;
        fs_sav_lim_o  = sav_q[0].lim;
        fs_sav_ar_o   = sav_q[0].ar;
        gs_sav_sel_o  = sav_q[1].sel;
        gs_sav_base_o = sav_q[1].base;
        gs_sav_lim_o  = sav_q[1].lim;
        gs_sav_ar_o   = sav_q[1].ar;
    end
endmodule

// File: rtl/segb_chk.sv
// Checker: temporal properties of the FS/GS segment builder, bound to the top.
// Assumes request inputs are stable around the sampling edge.
module segb_chk
    import segb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              mode64_i,
    input logic [31:0]       fs_ofs_i,
    input logic [31:0]       gs_ofs_i,
    input logic [31:0]       fs_lim_i,
    input logic [31:0]       gs_lim_i,
    input logic [BASE_W-1:0] fs_cur_base_i,
    input logic [BASE_W-1:0] gs_cur_base_i,
    input logic              done_o,
    input logic              fault_o,
    input logic [SEL_W-1:0]  fs_sel_o,
    input logic [SEL_W-1:0]  gs_sel_o,
    input logic [BASE_W-1:0] fs_base_o,
    input logic [BASE_W-1:0] gs_base_o,
    input logic [LIM_W-1:0]  fs_lim_o,
    input logic [LIM_W-1:0]  gs_lim_o,
    input logic [AR_W-1:0]   fs_ar_o,
    input logic [AR_W-1:0]   gs_ar_o,
    input logic [BASE_W-1:0] fs_sav_base_o,
    input logic [BASE_W-1:0] gs_sav_base_o
);
    p_done_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);

    p_align_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ((|fs_ofs_i[11:0]) || (|gs_ofs_i[11:0]))) |=> fault_o);

    p_limit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |->
            (fs_lim_o == $past(fs_lim_i) && gs_lim_o == $past(gs_lim_i)));

    p_canonical_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && $past(mode64_i)) |->
            (!canon_bad(fs_base_o, 47) && !canon_bad(gs_base_o, 47)));

    p_fixed_ar_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |->
            (fs_ar_o[3:0] == 4'b0001 && gs_ar_o[3:0] == 4'b0001 &&
             !fs_ar_o[13] && !gs_ar_o[13] && fs_ar_o[12] && gs_ar_o[8]));

    p_selector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> (fs_sel_o == 16'h000B && gs_sel_o == 16'h000B));

    p_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |->
            (fs_sav_base_o == $past(fs_cur_base_i) &&
             gs_sav_base_o == $past(gs_cur_base_i)));

    p_hold_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |->
            ($stable(fs_base_o) && $stable(gs_base_o) && $stable(fs_lim_o) &&
             $stable(gs_lim_o) && $stable(fs_sav_base_o) && $stable(gs_sav_base_o)));
endmodule

bind seg_entry_builder segb_chk u_segb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .mode64_i      (mode64_i),
    .fs_ofs_i      (fs_ofs_i),
    .gs_ofs_i      (gs_ofs_i),
    .fs_lim_i      (fs_lim_i),
    .gs_lim_i      (gs_lim_i),
    .fs_cur_base_i (fs_cur_base_i),
    .gs_cur_base_i (gs_cur_base_i),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fs_sel_o      (fs_sel_o),
    .gs_sel_o      (gs_sel_o),
    .fs_base_o     (fs_base_o),
    .gs_base_o     (gs_base_o),
    .fs_lim_o      (fs_lim_o),
    .gs_lim_o      (gs_lim_o),
    .fs_ar_o       (fs_ar_o),
    .gs_ar_o       (gs_ar_o),
    .fs_sav_base_o (fs_sav_base_o),
    .gs_sav_base_o (gs_sav_base_o)
);

// File: tb/sim_seg_entry_builder.sv
// Bench: scoreboard. The driver computes expected results from the requirements
// and queues them. The monitor compares them when done_o pulses.
module sim_seg_entry_builder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic              fault;
        logic [1:0][15:0]  nsel;
        logic [1:0][63:0]  nbase;
        logic [1:0][31:0]  nlim;
        logic [1:0][13:0]  nar;
        logic [1:0][15:0]  ssel;
        logic [1:0][63:0]  sbase;
        logic [1:0][31:0]  slim;
        logic [1:0][13:0]  sar;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic mode64 = 1'b0;
    logic [31:0] eb = '0;
    logic [31:0] dsl = '0;
    logic ds_w = 1'b0, ds_avl = 1'b0, ds_l = 1'b0;
    logic [1:0] ds_dpl = '0;
    logic [31:0] ofs [2];
    logic [31:0] lim [2];
    logic [63:0] rb [2];
    logic [15:0] csel [2];
    logic [63:0] cbase [2];
    logic [31:0] clim [2];
    logic [13:0] car [2];

    logic done, fault;
    logic [15:0] fs_sel, gs_sel, fs_ssel, gs_ssel;
    logic [63:0] fs_base, gs_base, fs_sbase, gs_sbase;
    logic [31:0] fs_lim, gs_lim, fs_slim, gs_slim;
    logic [13:0] fs_ar, gs_ar, fs_sar, gs_sar;

    int checks = 0;
    int errors = 0;
    exp_t  expq [$];
    string tagq [$];
    exp_t  mdl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_entry_builder u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode64_i(mode64),
        .encl_base_i(eb), .ds_limit_i(dsl), .ds_w_i(ds_w), .ds_dpl_i(ds_dpl),
        .ds_avl_i(ds_avl), .ds_l_i(ds_l),
        .fs_ofs_i(ofs[0]), .fs_lim_i(lim[0]), .fs_rbase_i(rb[0]),
        .gs_ofs_i(ofs[1]), .gs_lim_i(lim[1]), .gs_rbase_i(rb[1]),
        .fs_cur_sel_i(csel[0]), .fs_cur_base_i(cbase[0]),
        .fs_cur_lim_i(clim[0]), .fs_cur_ar_i(car[0]),
        .gs_cur_sel_i(csel[1]), .gs_cur_base_i(cbase[1]),
        .gs_cur_lim_i(clim[1]), .gs_cur_ar_i(car[1]),
        .done_o(done), .fault_o(fault),
        .fs_sel_o(fs_sel), .fs_base_o(fs_base), .fs_lim_o(fs_lim), .fs_ar_o(fs_ar),
        .gs_sel_o(gs_sel), .gs_base_o(gs_base), .gs_lim_o(gs_lim), .gs_ar_o(gs_ar),
        .fs_sav_sel_o(fs_ssel), .fs_sav_base_o(fs_sbase),
        .fs_sav_lim_o(fs_slim), .fs_sav_ar_o(fs_sar),
        .gs_sav_sel_o(gs_ssel), .gs_sav_base_o(gs_sbase),
        .gs_sav_lim_o(gs_slim), .gs_sav_ar_o(gs_sar)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: compute expected result from the requirements, queue it, pulse req
    task automatic go(input string tag);
        exp_t e;
        logic [1:0] f;
        logic [63:0] nb [2];
        e = mdl;
        for (int i = 0; i < 2; i++) begin
            logic [31:0] b32, e32;
            f[i] = (ofs[i][11:0] != 12'h0);                            // R2
            if (mode64) begin                                           // R6
                nb[i] = rb[i];
                if (!((&rb[i][63:47]) || (rb[i][63:47] == 17'h0))) f[i] = 1'b1;
            end else begin
                b32 = ofs[i] + eb;                                      // R3
                e32 = b32 + lim[i];
                nb[i] = {32'h0, b32};
                if (e32 < b32) begin                                    // R5
                    if (dsl != 32'hFFFF_FFFF) f[i] = 1'b1;
                end else if (e32 > dsl) f[i] = 1'b1;                    // R4
            end
        end
        e.fault = f[0] | f[1];                                          // R11
        if (!e.fault) begin
            for (int i = 0; i < 2; i++) begin
                e.nsel[i]  = 16'h000B;                                  // R8
                e.nbase[i] = nb[i];
                e.nlim[i]  = lim[i];
                e.nar[i]   = {1'b0, 1'b1, 1'b1, ds_l, ds_avl, 1'b1,
                              ds_dpl, 1'b1, ds_w, 4'b0001};             // R7 R8
                e.ssel[i]  = csel[i];                                   // R9
                e.sbase[i] = cbase[i];
                e.slim[i]  = clim[i];
                e.sar[i]   = car[i];
            end
            mdl = e;
        end else begin
            mdl.fault = 1'b1;                                           // R10 hold
        end
        expq.push_back(e);
        tagq.push_back(tag);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // monitor: compare against the queue whenever a result appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(t, "fault", {63'h0, fault}, {63'h0, e.fault});
                chk(t, "fs_sel", {48'h0, fs_sel}, {48'h0, e.nsel[0]});
                chk(t, "gs_sel", {48'h0, gs_sel}, {48'h0, e.nsel[1]});
                chk(t, "fs_base", fs_base, e.nbase[0]);
                chk(t, "gs_base", gs_base, e.nbase[1]);
                chk(t, "fs_lim", {32'h0, fs_lim}, {32'h0, e.nlim[0]});
                chk(t, "gs_lim", {32'h0, gs_lim}, {32'h0, e.nlim[1]});
                chk(t, "fs_ar", {50'h0, fs_ar}, {50'h0, e.nar[0]});
                chk(t, "gs_ar", {50'h0, gs_ar}, {50'h0, e.nar[1]});
                chk(t, "fs_ssel", {48'h0, fs_ssel}, {48'h0, e.ssel[0]});
                chk(t, "gs_ssel", {48'h0, gs_ssel}, {48'h0, e.ssel[1]});
                chk(t, "fs_sbase", fs_sbase, e.sbase[0]);
                chk(t, "gs_sbase", gs_sbase, e.sbase[1]);
                chk(t, "fs_slim", {32'h0, fs_slim}, {32'h0, e.slim[0]});
                chk(t, "gs_slim", {32'h0, gs_slim}, {32'h0, e.slim[1]});
                chk(t, "fs_sar", {50'h0, fs_sar}, {50'h0, e.sar[0]});
                chk(t, "gs_sar", {50'h0, gs_sar}, {50'h0, e.sar[1]});
            end
        end
    end

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic set_cur(input logic [15:0] s, input logic [63:0] b);
        csel[0] = s;          cbase[0] = b;
        clim[0] = 32'h0000_FFFF ^ {16'h0, s}; car[0] = 14'h0A5A ^ s[13:0];
        csel[1] = s + 16'h8;  cbase[1] = ~b;
        clim[1] = 32'h000F_0000 | {16'h0, s}; car[1] = 14'h15A5 ^ s[13:0];
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            ofs[i] = '0; lim[i] = '0; rb[i] = '0;
            csel[i] = '0; cbase[i] = '0; clim[i] = '0; car[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", "done", {63'h0, done}, 64'h0);
        chk("R1 reset", "fault", {63'h0, fault}, 64'h0);
        chk("R1 reset", "fs_base", fs_base, 64'h0);
        chk("R1 reset", "gs_sav_base", gs_sbase, 64'h0);
        chk("R1 reset", "fs_ar", {50'h0, fs_ar}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", "done", {63'h0, done}, 64'h0);

        // R3 R7 R8 R9: legal 32-bit build
        mode64 = 0; eb = 32'h0010_0000; dsl = 32'h0FFF_FFFF;
        ds_w = 1; ds_dpl = 2'd3; ds_avl = 1; ds_l = 0;
        ofs[0] = 32'h2000; ofs[1] = 32'h5000; lim[0] = 32'hFFF; lim[1] = 32'h1FFF;
        set_cur(16'h0033, 64'h0000_1234_5678_9000);
        go("R3 R7 R8 R9 basic32");
        @(negedge clk);

        // R4 boundary: end equals DS limit is accepted, then one byte past faults
        dsl = 32'h0020_0000; ofs[0] = 32'h1000; lim[0] = 32'h000F_F000;
        ds_w = 0; ds_dpl = 2'd1; ds_avl = 0; ds_l = 1;
        set_cur(16'h0041, 64'h0000_0000_00AB_C000);
        go("R4 R8 end_at_limit");
        lim[0] = 32'h000F_F001;
        set_cur(16'h0052, 64'h0000_0000_0DEF_0000);
        go("R4 R10 end_past_limit");
        @(negedge clk);

        // R2 misaligned FS, then R11 misaligned GS only
        lim[0] = 32'h100; ofs[0] = 32'h2010;
        go("R2 R10 fs_misaligned");
        ofs[0] = 32'h2000; ofs[1] = 32'h5800;
        go("R11 R2 gs_misaligned");
        ofs[1] = 32'h5000;

        // R5 wrap: full DS accepted, DS one short faults
        eb = 32'hFFFF_0000; ofs[0] = 32'h8000; lim[0] = 32'h0001_0000;
        ofs[1] = 32'h1000; lim[1] = 32'h10;
        dsl = 32'hFFFF_FFFF;
        set_cur(16'h0063, 64'h0000_0000_7000_0000);
        go("R5 wrap_full_ds");
        dsl = 32'hFFFF_FFFE;
        set_cur(16'h0074, 64'h0000_0000_7100_0000);
        go("R5 R10 wrap_short_ds");
        @(negedge clk);

        // R3 base modulo 2^32 (zero base), GS wrap alone on short DS (R11)
        eb = 32'hFFFF_F000; ofs[0] = 32'h1000; lim[0] = 32'h100;
        ofs[1] = 32'h0; lim[1] = 32'h10; dsl = 32'hFFFF_FFFF;
        set_cur(16'h0085, 64'h0000_0000_7200_0000);
        go("R3 base_mod32");
        ofs[1] = 32'h0; lim[1] = 32'h2000; dsl = 32'h7FFF_FFFF;
        go("R11 R5 gs_wrap_only");

        // R6 64-bit: canonical bases on both halves, tiny DS limit ignored
        mode64 = 1; dsl = 32'h10; ofs[0] = 32'h3000; ofs[1] = 32'h0;
        lim[0] = 32'hABC; lim[1] = 32'hFFFF_FFFF;
        rb[0] = 64'hFFFF_8000_0000_1000; rb[1] = 64'h0000_7FFF_FFFF_F000;
        set_cur(16'h0096, 64'hFFFF_FFFF_0000_0000);
        go("R6 R3 canonical64");
        rb[0] = 64'h0000_8000_0000_0000;
        go("R6 R10 fs_noncanonical");
        rb[0] = 64'h0000_0000_0000_2000; rb[1] = 64'hFFFF_7FFF_FFFF_0000;
        go("R6 R11 gs_noncanonical");
        rb[1] = 64'h0;
        ofs[0] = 32'h3001;
        go("R2 misaligned64");
        ofs[0] = 32'h3000;
        ds_w = 1; ds_dpl = 2'd2; ds_avl = 1; ds_l = 1;
        set_cur(16'h00A7, 64'h0000_0000_0000_0001);
        go("R6 R8 R9 final64");

        repeat (3) @(negedge clk);
        chk("R1 idle_end", "done", {63'h0, done}, 64'h0);
        chk("R1 queue_drained", "pending", {32'h0, 32'(expq.size())}, 64'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule